// File: doc/BRIEF.md
# SPI Clock Divider with Interval Timer

This block divides the system clock by a 16-bit reload value. While the SPI function is enabled, it paces an SPI master. It produces a toggle strobe at each serial-clock edge, a registered serial-clock level, and a bit strobe at each falling edge for the shifter. The divider runs only while a transfer is in progress. At other times the serial clock stays low.

When the SPI function is disabled, the same counter runs as a continuous interval timer. Each time it reaches terminal count it reloads itself with no gap. If the interrupt enable is set, each time-out sets a sticky interrupt flag, which software clears by writing a one.

A reload value of zero means a period of 65536 cycles. To use the timer, software disables the SPI, writes the reload value, and then sets the interrupt enable.

Top module: `spi_baud_timer`

## Requirements
- R1: While rst_ni is low, sck_o, sck_toggle_o, bit_tick_o and irq_o are all 0. The reload register resets to 0, which means a period of 65536.
- R2: With spi_en_i low, the counter times out every N clock edges. A time-out takes effect on the N-th edge after a reload write or a restart. N is the reload value. xfer_active_i has no effect in this mode.
- R3: A reload value of 0 gives a period of 65536 cycles.
- R4: In timer mode, time-outs repeat every N edges with no idle cycle between periods.
- R5: irq_o stays at 1 until a cycle with irq_clr_i high. If a time-out and a clear fall in the same cycle, the time-out wins and irq_o stays 1.
- R6: A time-out sets irq_o only when irq_en_i is 1 and spi_en_i is 0. SPI-mode periods never set irq_o.
- R7: With spi_en_i and xfer_active_i both high, sck_toggle_o pulses for one cycle every N edges and sck_o inverts on that same edge. bit_tick_o pulses together with a toggle in which sck_o goes from 1 to 0.
- R8: In SPI mode with xfer_active_i low, the count is held at its start, sck_o is 0, and no strobes occur. When xfer_active_i rises, a full period begins.
- R9: In SPI mode, a reload value of 1 is treated as 2. The serial clock is therefore never faster than the system clock divided by 4.
- R10: A reload write restarts the count from the new value on the next cycle. Any period in progress is dropped.
- R11: A change of spi_en_i restarts the count. No time-out occurs in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_we_i | input | 1 | Write strobe for the reload register |
| reload_wdata_i | input | 16 | Reload value (0 means 65536) |
| spi_en_i | input | 1 | 1 selects SPI clock mode, 0 selects timer mode |
| xfer_active_i | input | 1 | SPI transfer in progress |
| irq_en_i | input | 1 | Enables the time-out interrupt in timer mode |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| sck_o | output | 1 | Serial clock level, idle low |
| sck_toggle_o | output | 1 | One-cycle strobe at each serial-clock edge |
| bit_tick_o | output | 1 | One-cycle strobe at each falling serial-clock edge |
| irq_o | output | 1 | Sticky time-out interrupt flag |

## Verification
The interrupt flag can receive a timer time-out and a clear write in the same cycle. The bench provokes this in a directed phase that holds irq_clr_i high throughout a short timer run, so that every time-out coincides with a clear. Random stimulus drives irq_clr_i on about one cycle in six, which adds more such collisions. A cycle model in the bench predicts set-over-clear precedence, and every collision must show irq_o at 1 in the following cycle. A reload write or a mode change that lands on a terminal-count cycle is the second collision, and the model judges it too: the restart must win and no strobe may follow.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_SPI   = 1'b1
  } brg_mode_e;
endpackage

// File: rtl/brg_counter.sv
module brg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tc_o    = run_i && !restart_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (restart_i || !run_i || at_zero) begin
      cnt_q <= load_val_i;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/brg_sck_gen.sv
module brg_sck_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tc_i,
  output logic sck_o,
  output logic toggle_o,
  output logic tick_o
);
  logic sck_q, toggle_q, tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      toggle_q <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      toggle_q <= active_i && tc_i;
      tick_q   <= active_i && tc_i && sck_q;
      if (!active_i)  sck_q <= 1'b0;
      else if (tc_i)  sck_q <= !sck_q;
    end
  end

  assign sck_o    = sck_q;
  assign toggle_o = toggle_q;
  assign tick_o   = tick_q;
endmodule

// File: rtl/brg_timeout_irq.sv
module brg_timeout_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic timeout_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  // new time-out beats a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (timeout_i) irq_q <= 1'b1;
    else if (clr_i)     irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_baud_timer.sv
module spi_baud_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             spi_en_i,
  input  logic             xfer_active_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             sck_o,
  output logic             sck_toggle_o,
  output logic             bit_tick_o,
  output logic             irq_o
);
  import spi_brg_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  brg_mode_e        mode, mode_q;
  logic [CNT_W-1:0] reload_q, reload_nxt, load_val;
  logic             run, restart, tc, spi_active;

  assign mode       = spi_en_i ? MODE_SPI : MODE_TIMER;
  assign reload_nxt = reload_we_i ? reload_wdata_i : reload_q;
  assign spi_active = (mode == MODE_SPI) && xfer_active_i;
  assign run        = (mode == MODE_TIMER) || xfer_active_i;
  assign restart    = reload_we_i || (mode != mode_q);

  // counter holds N-1; 0 wraps to all-ones (65536); SPI clamps 1 up to 2
  always_comb begin
    if ((mode == MODE_SPI) && (reload_nxt == ONE)) load_val = ONE;
    else                                           load_val = reload_nxt - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      mode_q   <= MODE_TIMER;
    end else begin
      reload_q <= reload_nxt;
      mode_q   <= mode;
    end
  end

  brg_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .restart_i  (restart),
    .load_val_i (load_val),
    .tc_o       (tc)
  );

  brg_sck_gen i_sck_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (spi_active),
    .tc_i     (tc),
    .sck_o    (sck_o),
    .toggle_o (sck_toggle_o),
    .tick_o   (bit_tick_o)
  );

  brg_timeout_irq i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .timeout_i (tc && (mode == MODE_TIMER) && irq_en_i),
    .clr_i     (irq_clr_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/spi_baud_timer_chk.sv
module spi_baud_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_we_i,
  input logic [CNT_W-1:0] reload_wdata_i,
  input logic             spi_en_i,
  input logic             xfer_active_i,
  input logic             irq_en_i,
  input logic             irq_clr_i,
  input logic             sck_o,
  input logic             sck_toggle_o,
  input logic             bit_tick_o,
  input logic             irq_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !sck_o && !sck_toggle_o && !bit_tick_o && !irq_o);

  // R5
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  // R6
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |=> !irq_o || $past(irq_en_i && !spi_en_i));

  // R7
  toggle_flips_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_i && xfer_active_i |=> sck_toggle_o == (sck_o != $past(sck_o)));

  // R7
  tick_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sck_toggle_o && !sck_o);

  // R8
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spi_en_i && xfer_active_i) |=> !sck_o && !sck_toggle_o);

  // R9
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_toggle_o |=> !sck_toggle_o);
endmodule

bind spi_baud_timer spi_baud_timer_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_spi_baud_timer.sv
module test_spi_baud_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic        spi = 1'b0, act = 1'b0, ien = 1'b0, clr = 1'b0;
  logic        sck, tog, tick, irq;

  int vectors = 0, errors = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  int   m_reload, m_left;
  bit   m_spi_q, m_sck, e_sck, e_tog, e_tick, e_irq;

  always #4 clk = !clk;

  spi_baud_timer i_spi_baud_timer (
    .clk_i(clk), .rst_ni(rst_n), .reload_we_i(we), .reload_wdata_i(wd),
    .spi_en_i(spi), .xfer_active_i(act), .irq_en_i(ien), .irq_clr_i(clr),
    .sck_o(sck), .sck_toggle_o(tog), .bit_tick_o(tick), .irq_o(irq));

  function automatic int period(int r, bit s);
    if (r == 0) return 65536;
    if (s && r == 1) return 2;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reload = 0; m_left = 65536; m_spi_q = 0; m_sck = 0;
      e_sck = 0; e_tog = 0; e_tick = 0; e_irq = 0;
    end else begin
      int nr; bit ev;
      nr = we ? int'(wd) : m_reload;
      ev = 0;
      if (we || (spi != m_spi_q) || (spi && !act)) m_left = period(nr, spi);
      else if (m_left == 1) begin ev = 1; m_left = period(nr, spi); end
      else m_left--;
      e_tog  = ev && spi && act;
      e_tick = e_tog && m_sck;
      if (!(spi && act)) m_sck = 0; else if (ev) m_sck = !m_sck;
      e_sck = m_sck;
      if (ev && !spi && ien) e_irq = 1; else if (clr) e_irq = 0;
      m_reload = nr; m_spi_q = spi;
    end
  end

  task automatic chk(string t, logic act_v, logic exp_v, string what);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", t, what, act_v, exp_v, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk(tag, sck,  e_sck,  "sck_o");
    chk(tag, tog,  e_tog,  "sck_toggle_o");
    chk(tag, tick, e_tick, "bit_tick_o");
    chk(tag, irq,  e_irq,  "irq_o");
  endtask

  task automatic write_reload(int v);
    we = 1'b1; wd = 16'(v);
    step();
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int gap;
    // R1 reset state
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R2 R4 timer mode, xfer_active toggling has no effect
    tag = "R2"; ien = 1; act = 1;
    write_reload(5);
    for (int i = 0; i < 40; i++) begin
      act = 1'($urandom_range(0, 1)); clr = (i % 7 == 3);
      step();
    end
    clr = 0;
    tag = "R4";
    write_reload(3);
    for (int i = 0; i < 30; i++) begin clr = irq; step(); end
    clr = 0;

    // R5 clear held high: each time-out still raises irq
    tag = "R5"; clr = 1;
    write_reload(4);
    for (int i = 0; i < 20; i++) step();
    clr = 0; step(); step();

    // R6 interrupt disabled, then SPI mode periods
    tag = "R6"; clr = 1; step(); clr = 0; ien = 0;
    for (int i = 0; i < 20; i++) step();
    ien = 1; spi = 1; act = 1;
    for (int i = 0; i < 20; i++) step();

    // R7 SPI clocking
    tag = "R7";
    write_reload(3);
    for (int i = 0; i < 30; i++) step();

    // R8 pause and resume transfer
    tag = "R8"; act = 0;
    for (int i = 0; i < 10; i++) step();
    act = 1;
    for (int i = 0; i < 12; i++) step();

    // R9 reload 1 in SPI mode gives divide by 4
    tag = "R9";
    write_reload(1);
    for (int i = 0; i < 16; i++) step();

    // R10 rewrite mid-period
    tag = "R10";
    write_reload(6); step(); step();
    write_reload(2);
    for (int i = 0; i < 10; i++) step();

    // R11 mode changes mid-count
    tag = "R11";
    for (int i = 0; i < 6; i++) begin
      spi = !spi;
      repeat (i + 1) step();
    end
    spi = 0;

    // random mix
    tag = "R2";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 63) == 0) begin
        we = 1; wd = 16'($urandom_range(0, 7));
      end else we = 0;
      if ($urandom_range(0, 99) == 0) spi = !spi;
      if ($urandom_range(0, 15) == 0) act = !act;
      if ($urandom_range(0, 31) == 0) ien = !ien;
      clr = ($urandom_range(0, 5) == 0);
      step();
    end
    we = 0; clr = 0;

    // R3 reload 0 spans 65536 cycles
    tag = "R3"; spi = 0; ien = 1; clr = 1; step(); clr = 0;
    write_reload(0);
    gap = 1;
    while (!irq && gap < 70000) begin step(); gap++; end
    vectors++;
    if (gap != 65537) begin
      errors++;
      $display("FAIL R3 irq delay: actual %0d expected %0d", gap - 1, 65536);
    end
    step();
    finish_run();
  end
endmodule